// File: doc/BRIEF.md
# Base Integer Instruction Decoder

This block turns one 32-bit base-integer instruction word into an operation code and the operand fields an execution stage needs. It is purely combinational: the word on the input produces the code, the illegal flag, the three register indices, the 12-bit control-status register address and all five immediate forms in the same cycle, with no clock and no state.

The decoder covers the integer register and immediate arithmetic, loads, stores, branches, jumps, the two upper-immediate operations, the memory fence, the six control-status register access operations and the system group (environment call and break, the three trap returns, wait-for-interrupt and the virtual-memory fence). Any word outside that set gives code zero and raises the illegal flag. Funct7 values are checked strictly, and a shift-left-immediate whose shift amount would need a sixth bit is rejected. The field and immediate outputs are always driven from the word, whether it is legal or not, so the consumer picks the ones its code calls for.

Top module: `int32_instr_decoder`

## Requirements
- R1: Only the major opcodes (bits 6:0) 0110111, 0010111, 1101111, 1100111, 1100011, 0000011, 0100011, 0010011, 0110011, 0001111 and 1110011 can decode; any other value, the all-zero and all-ones words included, gives code 0.
- R2: op_o codes: 1 load-upper, 2 add-upper-to-pc, 3 jump-and-link, 4 jump-and-link-register; branches 8..13 (equal, not-equal, less, greater-or-equal, less-unsigned, greater-or-equal-unsigned); loads 16..20 (byte, half, word, byte-unsigned, half-unsigned); stores 24..26 (byte, half, word); immediate ops 32 add, 33 set-less, 34 set-less-unsigned, 35 xor, 36 or, 37 and, 38 shift-left, 39 shift-right-logical, 40 shift-right-arith; register ops 48 add, 49 sub, 50 shift-left, 51 set-less, 52 set-less-unsigned, 53 xor, 54 shift-right-logical, 55 shift-right-arith, 56 or, 57 and; 64 fence, 65 env-call, 66 env-break, 67 user-return, 68 supervisor-return, 69 machine-return, 70 wait-for-interrupt, 71 vm-fence; register access 72 write, 73 set, 74 clear, 75 write-imm, 76 set-imm, 77 clear-imm.
- R3: Under major 1100011, funct3 (bits 14:12) 000, 001, 100, 101, 110, 111 give codes 8..13 in that order; 010 and 011 give code 0.
- R4: Under major 0000011, funct3 000, 001, 010, 100, 101 give codes 16..20 in that order, others code 0; under major 0100011, funct3 000, 001, 010 give 24..26, others code 0.
- R5: Under 0010011 and 0110011, funct3 000 is add, 010 set-less, 011 set-less-unsigned, 100 xor, 110 or, 111 and, 001 shift-left, 101 shift-right, with codes as in R2.
- R6: Funct7 (bits 31:25) must be 0000000 under 0110011, except that funct3 000 and 101 also accept 0100000 (sub, shift-right-arith); under 0010011 funct3 101 takes 0000000 (logical) or 0100000 (arith); every other funct7 there gives code 0.
- R7: A shift-left-immediate (0010011, funct3 001) needs bits 31:25 all zero; bit 25 set (a sixth shift-amount bit) or any other bit of that field set gives code 0.
- R8: Under 1110011 with funct3 000, bits 31:20 equal to 0x000, 0x001, 0x002, 0x102, 0x302, 0x105 give codes 65..70; otherwise bits 31:25 equal to 0001001 give 71; anything else code 0.
- R9: Under 1110011, funct3 001, 010, 011, 101, 110, 111 give codes 72..77 and funct3 100 gives code 0; csr_o always equals bits 31:20.
- R10: Jump-and-link-register (1100111) and fence (0001111) decode only with funct3 000; other funct3 gives code 0.
- R11: rd_o, rs1_o and rs2_o always equal bits 11:7, 19:15 and 24:20, legal or not.
- R12: imm_i_o is bits 31:20 sign-extended; imm_s_o is {bits 31:25, bits 11:7} sign-extended; imm_b_o is {bit 31, bit 7, bits 30:25, bits 11:8, 0} sign-extended.
- R13: imm_u_o is bits 31:12 followed by twelve zeros; imm_j_o is {bit 31, bits 19:12, bit 20, bits 30:21, 0} sign-extended.
- R14: illegal_o is 1 exactly when op_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| op_o | output | 7 | Operation code, 0 when not recognised |
| illegal_o | output | 1 | High for an unrecognised word |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| csr_o | output | 12 | Control-status register address / system function field |
| imm_i_o | output | 32 | Immediate, register-immediate format |
| imm_s_o | output | 32 | Immediate, store format |
| imm_b_o | output | 32 | Immediate, branch format |
| imm_u_o | output | 32 | Immediate, upper format |
| imm_j_o | output | 32 | Immediate, jump format |

## Verification
With no storage, a wrong internal value shows at the ports in the same cycle as the offending word, so each vector is checked half a clock after it is applied. A mis-sliced field would corrupt both the code and the matching index or immediate output, while a wrong funct7 or shift-amount test shows as a legal code where zero was expected, or the reverse. The sweeps cover every major opcode, every funct3 under each decoded major with a spread of funct7 values, and all 4096 values of the system function field, so a single wrong case arm surfaces on the first word that selects it.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int ILEN    = 32;
  localparam int MAJ_W   = 7;
  localparam int RIDX_W  = 5;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int CSRA_W  = 12;
  localparam int CODE_W  = 7;
  localparam int NUM_FMT = 5;

  localparam int RD_LSB  = MAJ_W;
  localparam int F3_LSB  = RD_LSB + RIDX_W;
  localparam int RS1_LSB = F3_LSB + F3_W;
  localparam int RS2_LSB = RS1_LSB + RIDX_W;
  localparam int F7_LSB  = RS2_LSB + RIDX_W;

  localparam logic [MAJ_W-1:0] MAJ_LUI    = 7'b0110111;
  localparam logic [MAJ_W-1:0] MAJ_AUIPC  = 7'b0010111;
  localparam logic [MAJ_W-1:0] MAJ_JAL    = 7'b1101111;
  localparam logic [MAJ_W-1:0] MAJ_JALR   = 7'b1100111;
  localparam logic [MAJ_W-1:0] MAJ_BRANCH = 7'b1100011;
  localparam logic [MAJ_W-1:0] MAJ_LOAD   = 7'b0000011;
  localparam logic [MAJ_W-1:0] MAJ_STORE  = 7'b0100011;
  localparam logic [MAJ_W-1:0] MAJ_OPIMM  = 7'b0010011;
  localparam logic [MAJ_W-1:0] MAJ_OPREG  = 7'b0110011;
  localparam logic [MAJ_W-1:0] MAJ_MISC   = 7'b0001111;
  localparam logic [MAJ_W-1:0] MAJ_SYS    = 7'b1110011;

  localparam logic [F7_W-1:0]   F7_BASE    = 7'b0000000;
  localparam logic [F7_W-1:0]   F7_ALT     = 7'b0100000;
  localparam logic [F7_W-1:0]   VMF_PREFIX = 7'b0001001;

  localparam logic [CSRA_W-1:0] SYS_ECALL  = 12'h000;
  localparam logic [CSRA_W-1:0] SYS_EBREAK = 12'h001;
  localparam logic [CSRA_W-1:0] SYS_URET   = 12'h002;
  localparam logic [CSRA_W-1:0] SYS_SRET   = 12'h102;
  localparam logic [CSRA_W-1:0] SYS_MRET   = 12'h302;
  localparam logic [CSRA_W-1:0] SYS_WFI    = 12'h105;

  typedef enum logic [CODE_W-1:0] {
    OPC_ILLEGAL  = 7'd0,
    OPC_LUI      = 7'd1,  OPC_AUIPC  = 7'd2,  OPC_JAL    = 7'd3,  OPC_JALR  = 7'd4,
    OPC_BEQ      = 7'd8,  OPC_BNE    = 7'd9,  OPC_BLT    = 7'd10, OPC_BGE   = 7'd11,
    OPC_BLTU     = 7'd12, OPC_BGEU   = 7'd13,
    OPC_LB       = 7'd16, OPC_LH     = 7'd17, OPC_LW     = 7'd18, OPC_LBU   = 7'd19,
    OPC_LHU      = 7'd20,
    OPC_SB       = 7'd24, OPC_SH     = 7'd25, OPC_SW     = 7'd26,
    OPC_ADDI     = 7'd32, OPC_SLTI   = 7'd33, OPC_SLTIU  = 7'd34, OPC_XORI  = 7'd35,
    OPC_ORI      = 7'd36, OPC_ANDI   = 7'd37, OPC_SLLI   = 7'd38, OPC_SRLI  = 7'd39,
    OPC_SRAI     = 7'd40,
    OPC_ADD      = 7'd48, OPC_SUB    = 7'd49, OPC_SLL    = 7'd50, OPC_SLT   = 7'd51,
    OPC_SLTU     = 7'd52, OPC_XOR    = 7'd53, OPC_SRL    = 7'd54, OPC_SRA   = 7'd55,
    OPC_OR       = 7'd56, OPC_AND    = 7'd57,
    OPC_FENCE    = 7'd64, OPC_ENV_CALL = 7'd65, OPC_ENV_BREAK = 7'd66,
    OPC_RET_U    = 7'd67, OPC_RET_S  = 7'd68, OPC_RET_M  = 7'd69, OPC_WAIT_IRQ = 7'd70,
    OPC_VM_FENCE = 7'd71,
    OPC_REG_WR   = 7'd72, OPC_REG_SET = 7'd73, OPC_REG_CLR = 7'd74,
    OPC_REG_WRI  = 7'd75, OPC_REG_SETI = 7'd76, OPC_REG_CLRI = 7'd77
  } dec_op_e;

  typedef enum logic [2:0] {
    IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
  } imm_fmt_e;

  // Immediate assembly per format; bit positions are fixed by the encoding.
  function automatic logic [ILEN-1:0] build_imm(imm_fmt_e fmt, logic [ILEN-1:0] w);
    logic [ILEN-1:0] r;
    case (fmt)
      IMM_I:   r = {{20{w[31]}}, w[31:20]};
      IMM_S:   r = {{20{w[31]}}, w[31:25], w[11:7]};
      IMM_B:   r = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
      IMM_U:   r = {w[31:12], 12'b0};
      default: r = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [ILEN-1:0]   word_i,
  output logic [MAJ_W-1:0]  major_o,
  output logic [F3_W-1:0]   f3_o,
  output logic [F7_W-1:0]   f7_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [CSRA_W-1:0] f12_o
);

  assign major_o = word_i[0 +: MAJ_W];
  assign rd_o    = word_i[RD_LSB  +: RIDX_W];
  assign f3_o    = word_i[F3_LSB  +: F3_W];
  assign rs1_o   = word_i[RS1_LSB +: RIDX_W];
  assign rs2_o   = word_i[RS2_LSB +: RIDX_W];
  assign f7_o    = word_i[F7_LSB  +: F7_W];
  assign f12_o   = word_i[RS2_LSB +: CSRA_W];

endmodule

// File: rtl/idec_imm.sv
module idec_imm
  import idec_pkg::*;
#(
  parameter idec_pkg::imm_fmt_e FMT = idec_pkg::IMM_I
) (
  input  logic [ILEN-1:0] word_i,
  output logic [ILEN-1:0] imm_o
);

  assign imm_o = build_imm(FMT, word_i);

endmodule

// File: rtl/idec_sysop.sv
module idec_sysop
  import idec_pkg::*;
(
  input  logic [F3_W-1:0]   f3_i,
  input  logic [CSRA_W-1:0] f12_i,
  output dec_op_e           sys_op_o
);

  logic priv_group;
  logic vmf_match;

  assign priv_group = (f3_i == 3'b000);
  assign vmf_match  = (f12_i[CSRA_W-1 -: F7_W] == VMF_PREFIX);

  always_comb begin
    sys_op_o = OPC_ILLEGAL;
    if (priv_group) begin
      case (f12_i)
        SYS_ECALL:  sys_op_o = OPC_ENV_CALL;
        SYS_EBREAK: sys_op_o = OPC_ENV_BREAK;
        SYS_URET:   sys_op_o = OPC_RET_U;
        SYS_SRET:   sys_op_o = OPC_RET_S;
        SYS_MRET:   sys_op_o = OPC_RET_M;
        SYS_WFI:    sys_op_o = OPC_WAIT_IRQ;
        default:    if (vmf_match) sys_op_o = OPC_VM_FENCE;
      endcase
    end else begin
      case (f3_i)
        3'b001:  sys_op_o = OPC_REG_WR;
        3'b010:  sys_op_o = OPC_REG_SET;
        3'b011:  sys_op_o = OPC_REG_CLR;
        3'b101:  sys_op_o = OPC_REG_WRI;
        3'b110:  sys_op_o = OPC_REG_SETI;
        3'b111:  sys_op_o = OPC_REG_CLRI;
        default: sys_op_o = OPC_ILLEGAL;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({f3_i, f12_i})) begin
      AST_VMF_NEEDS_PREFIX: assert (sys_op_o != OPC_VM_FENCE || (vmf_match && priv_group)); // R8
      AST_REGACC_FUNCT3: assert (!(sys_op_o inside {OPC_REG_WR, OPC_REG_SET, OPC_REG_CLR,
                                                  OPC_REG_WRI, OPC_REG_SETI, OPC_REG_CLRI})
                                 || (f3_i != 3'b000 && f3_i != 3'b100)); // R9
    end
  end

endmodule

// File: rtl/idec_opsel.sv
module idec_opsel
  import idec_pkg::*;
(
  input  logic [MAJ_W-1:0] major_i,
  input  logic [F3_W-1:0]  f3_i,
  input  logic [F7_W-1:0]  f7_i,
  input  dec_op_e          sys_op_i,
  output dec_op_e          op_o
);

  logic f7_base;
  logic f7_alt;
  logic major_listed;

  assign f7_base = (f7_i == F7_BASE);
  assign f7_alt  = (f7_i == F7_ALT);
  assign major_listed = major_i inside {MAJ_LUI, MAJ_AUIPC, MAJ_JAL, MAJ_JALR, MAJ_BRANCH,
                                        MAJ_LOAD, MAJ_STORE, MAJ_OPIMM, MAJ_OPREG,
                                        MAJ_MISC, MAJ_SYS};

  always_comb begin
    op_o = OPC_ILLEGAL;
    case (major_i)
      MAJ_LUI:   op_o = OPC_LUI;
      MAJ_AUIPC: op_o = OPC_AUIPC;
      MAJ_JAL:   op_o = OPC_JAL;
      MAJ_JALR:  if (f3_i == 3'b000) op_o = OPC_JALR;
      MAJ_MISC:  if (f3_i == 3'b000) op_o = OPC_FENCE;
      MAJ_SYS:   op_o = sys_op_i;
      MAJ_BRANCH: begin
        case (f3_i)
          3'b000:  op_o = OPC_BEQ;
          3'b001:  op_o = OPC_BNE;
          3'b100:  op_o = OPC_BLT;
          3'b101:  op_o = OPC_BGE;
          3'b110:  op_o = OPC_BLTU;
          3'b111:  op_o = OPC_BGEU;
          default: op_o = OPC_ILLEGAL;
        endcase
      end
      MAJ_LOAD: begin
        case (f3_i)
          3'b000:  op_o = OPC_LB;
          3'b001:  op_o = OPC_LH;
          3'b010:  op_o = OPC_LW;
          3'b100:  op_o = OPC_LBU;
          3'b101:  op_o = OPC_LHU;
          default: op_o = OPC_ILLEGAL;
        endcase
      end
      MAJ_STORE: begin
        case (f3_i)
          3'b000:  op_o = OPC_SB;
          3'b001:  op_o = OPC_SH;
          3'b010:  op_o = OPC_SW;
          default: op_o = OPC_ILLEGAL;
        endcase
      end
      MAJ_OPIMM: begin
        case (f3_i)
          3'b000:  op_o = OPC_ADDI;
          3'b010:  op_o = OPC_SLTI;
          3'b011:  op_o = OPC_SLTIU;
          3'b100:  op_o = OPC_XORI;
          3'b110:  op_o = OPC_ORI;
          3'b111:  op_o = OPC_ANDI;
          3'b001:  if (f7_base) op_o = OPC_SLLI;
          default: begin
            if (f7_base)     op_o = OPC_SRLI;
            else if (f7_alt) op_o = OPC_SRAI;
          end
        endcase
      end
      MAJ_OPREG: begin
        if (f7_base) begin
          case (f3_i)
            3'b000:  op_o = OPC_ADD;
            3'b001:  op_o = OPC_SLL;
            3'b010:  op_o = OPC_SLT;
            3'b011:  op_o = OPC_SLTU;
            3'b100:  op_o = OPC_XOR;
            3'b101:  op_o = OPC_SRL;
            3'b110:  op_o = OPC_OR;
            default: op_o = OPC_AND;
          endcase
        end else if (f7_alt) begin
          if (f3_i == 3'b000)      op_o = OPC_SUB;
          else if (f3_i == 3'b101) op_o = OPC_SRA;
        end
      end
      default: op_o = OPC_ILLEGAL;
    endcase
  end

  always_comb begin
    if (!$isunknown({major_i, f3_i, f7_i})) begin
      AST_UNLISTED_MAJOR: assert (major_listed || op_o == OPC_ILLEGAL); // R1
      AST_BRANCH_RESERVED: assert (!(major_i == MAJ_BRANCH && f3_i[2:1] == 2'b01)
                                   || op_o == OPC_ILLEGAL); // R3
      AST_ALT_FORM_FUNCT7: assert (!(op_o inside {OPC_SUB, OPC_SRA, OPC_SRAI})
                                   || f7_i == F7_ALT); // R6
      AST_SLLI_WIDE_SHAMT: assert (!(major_i == MAJ_OPIMM && f3_i == 3'b001 && f7_i[0])
                                   || op_o == OPC_ILLEGAL); // R7
    end
  end

endmodule

// File: rtl/int32_instr_decoder.sv
module int32_instr_decoder
  import idec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [6:0]  op_o,
  output logic        illegal_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [11:0] csr_o,
  output logic [31:0] imm_i_o,
  output logic [31:0] imm_s_o,
  output logic [31:0] imm_b_o,
  output logic [31:0] imm_u_o,
  output logic [31:0] imm_j_o
);

  logic [MAJ_W-1:0]  major;
  logic [F3_W-1:0]   f3;
  logic [F7_W-1:0]   f7;
  logic [CSRA_W-1:0] f12;
  dec_op_e           sys_op;
  dec_op_e           op;
  logic [ILEN-1:0]   imm_bus [NUM_FMT];

  idec_fields u_fields (
    .word_i  (instr_i),
    .major_o (major),
    .f3_o    (f3),
    .f7_o    (f7),
    .rd_o    (rd_o),
    .rs1_o   (rs1_o),
    .rs2_o   (rs2_o),
    .f12_o   (f12)
  );

  idec_sysop u_sysop (
    .f3_i     (f3),
    .f12_i    (f12),
    .sys_op_o (sys_op)
  );

  idec_opsel u_opsel (
    .major_i  (major),
    .f3_i     (f3),
    .f7_i     (f7),
    .sys_op_i (sys_op),
    .op_o     (op)
  );

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_imm
    idec_imm #(.FMT(imm_fmt_e'(g))) u_imm (
      .word_i (instr_i),
      .imm_o  (imm_bus[g])
    );
  end

  assign op_o      = op;
  assign illegal_o = (op == OPC_ILLEGAL);
  assign csr_o     = f12;
  assign imm_i_o   = imm_bus[IMM_I];
  assign imm_s_o   = imm_bus[IMM_S];
  assign imm_b_o   = imm_bus[IMM_B];
  assign imm_u_o   = imm_bus[IMM_U];
  assign imm_j_o   = imm_bus[IMM_J];

  always_comb begin
    if (!$isunknown(instr_i)) begin
      AST_SYS_GROUP_MAJOR: assert (op_o < 7'd65 || instr_i[6:0] == MAJ_SYS); // R8
      AST_CSR_ADDR_FIELD: assert (csr_o == instr_i[31:20]); // R9
      AST_BRANCH_IMM_EVEN: assert (imm_b_o[0] == 1'b0 && imm_j_o[0] == 1'b0); // R12
    end
  end

endmodule

// File: tb/test_int32_instr_decoder.sv
`timescale 1ns/1ps
module test_int32_instr_decoder;

  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [6:0]  op_o;
  logic        illegal_o;
  logic [4:0]  rd_o, rs1_o, rs2_o;
  logic [11:0] csr_o;
  logic [31:0] imm_i_o, imm_s_o, imm_b_o, imm_u_o, imm_j_o;

  int  n_cmp  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  int32_instr_decoder i_int32_instr_decoder (
    .instr_i   (instr),
    .op_o      (op_o),
    .illegal_o (illegal_o),
    .rd_o      (rd_o),
    .rs1_o     (rs1_o),
    .rs2_o     (rs2_o),
    .csr_o     (csr_o),
    .imm_i_o   (imm_i_o),
    .imm_s_o   (imm_s_o),
    .imm_b_o   (imm_b_o),
    .imm_u_o   (imm_u_o),
    .imm_j_o   (imm_j_o)
  );

  function automatic logic [31:0] next_rand(logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Expected code per R2..R10, restated arithmetically from the requirements.
  function automatic int ref_code(logic [31:0] w);
    logic [6:0]  mj;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [11:0] f12;
    int c;
    mj = w[6:0]; f3 = w[14:12]; f7 = w[31:25]; f12 = w[31:20];
    c = 0;
    case (mj)
      7'h37: c = 1;
      7'h17: c = 2;
      7'h6F: c = 3;
      7'h67: c = (f3 == 0) ? 4 : 0;
      7'h63: c = (f3 == 2 || f3 == 3) ? 0 : ((f3 < 4) ? 8 + int'(f3) : 6 + int'(f3));
      7'h03: c = (f3 <= 2) ? 16 + int'(f3) : ((f3 == 4 || f3 == 5) ? 15 + int'(f3) : 0);
      7'h23: c = (f3 <= 2) ? 24 + int'(f3) : 0;
      7'h13: begin
        case (f3)
          3'd0: c = 32;
          3'd2: c = 33;
          3'd3: c = 34;
          3'd4: c = 35;
          3'd6: c = 36;
          3'd7: c = 37;
          3'd1: c = (f7 == 0) ? 38 : 0;
          default: c = (f7 == 0) ? 39 : ((f7 == 7'h20) ? 40 : 0);
        endcase
      end
      7'h33: begin
        if (f7 == 0)
          c = (f3 == 0) ? 48 : ((f3 <= 5) ? 49 + int'(f3) : 50 + int'(f3));
        else if (f7 == 7'h20)
          c = (f3 == 0) ? 49 : ((f3 == 5) ? 55 : 0);
      end
      7'h0F: c = (f3 == 0) ? 64 : 0;
      7'h73: begin
        if (f3 == 0) begin
          case (f12)
            12'h000: c = 65;
            12'h001: c = 66;
            12'h002: c = 67;
            12'h102: c = 68;
            12'h302: c = 69;
            12'h105: c = 70;
            default: c = (f7 == 7'h09) ? 71 : 0;
          endcase
        end else if (f3 == 4) c = 0;
        else c = (f3 < 4) ? 71 + int'(f3) : 70 + int'(f3);
      end
      default: c = 0;
    endcase
    return c;
  endfunction

  task automatic apply(input logic [31:0] w, input string tag);
    int              ec;
    logic signed [31:0] sw;
    logic [31:0]     ei, es, eb, eu, ej;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    ec = ref_code(w);
    sw = $signed(w);
    ei = 32'(sw >>> 20);
    es = (32'(sw >>> 20) & ~32'h1F) | ((w >> 7) & 32'h1F);
    eb = (32'(sw >>> 19) & 32'hFFFF_F000) | (((w >> 7) & 32'h1) << 11)
       | (((w >> 25) & 32'h3F) << 5) | (((w >> 8) & 32'hF) << 1);
    eu = w & 32'hFFFF_F000;
    ej = (32'(sw >>> 11) & 32'hFFF0_0000) | (w & 32'h000F_F000)
       | (((w >> 20) & 32'h1) << 11) | (((w >> 21) & 32'h3FF) << 1);

    n_cmp++;
    if (op_o !== ec[6:0]) begin
      n_bad++;
      $display("FAIL %s word=%h op actual=%0d expected=%0d", tag, w, op_o, ec);
    end
    n_cmp++;
    if (illegal_o !== (ec == 0)) begin
      n_bad++;
      $display("FAIL R14 word=%h illegal actual=%0b expected=%0b", w, illegal_o, ec == 0);
    end
    n_cmp++;
    if ({rd_o, rs1_o, rs2_o} !== {5'((w >> 7) & 31), 5'((w >> 15) & 31), 5'((w >> 20) & 31)}) begin
      n_bad++;
      $display("FAIL R11 word=%h idx actual=%0d/%0d/%0d expected=%0d/%0d/%0d", w,
               rd_o, rs1_o, rs2_o, (w >> 7) & 31, (w >> 15) & 31, (w >> 20) & 31);
    end
    n_cmp++;
    if (csr_o !== 12'(w >> 20)) begin
      n_bad++;
      $display("FAIL R9 word=%h csr actual=%h expected=%h", w, csr_o, w >> 20);
    end
    n_cmp++;
    if ({imm_i_o, imm_s_o, imm_b_o} !== {ei, es, eb}) begin
      n_bad++;
      $display("FAIL R12 word=%h imm actual=%h/%h/%h expected=%h/%h/%h", w,
               imm_i_o, imm_s_o, imm_b_o, ei, es, eb);
    end
    n_cmp++;
    if ({imm_u_o, imm_j_o} !== {eu, ej}) begin
      n_bad++;
      $display("FAIL R13 word=%h imm actual=%h/%h expected=%h/%h", w,
               imm_u_o, imm_j_o, eu, ej);
    end
  endtask

  function automatic string tag_for(logic [6:0] mj, logic [2:0] f3, logic [6:0] f7);
    string t;
    case (mj)
      7'h63:        t = "R3";
      7'h03, 7'h23: t = "R4";
      7'h67, 7'h0F: t = "R10";
      7'h13:        t = (f3 == 1) ? "R7" : ((f3 == 5) ? "R6" : "R5");
      7'h33:        t = (f7 != 0 || f3 == 0 || f3 == 5) ? "R6" : "R5";
      7'h73:        t = (f3 == 0) ? "R8" : "R9";
      default:      t = "R2";
    endcase
    return t;
  endfunction

  logic [6:0] majors [8] = '{7'h67, 7'h63, 7'h03, 7'h23, 7'h13, 7'h33, 7'h0F, 7'h73};
  logic [6:0] f7set  [6] = '{7'h00, 7'h20, 7'h01, 7'h40, 7'h7F, 7'h09};

  initial begin
    // All-zero word behaves like the idle/reset input: illegal (R1)
    apply(32'h0000_0000, "R1");
    apply(32'hFFFF_FFFF, "R1");

    // Every 7-bit major opcode with two body patterns (R1, R2)
    for (int m = 0; m < 128; m++) begin
      seed = next_rand(seed);
      apply({seed[31:7], 7'(m)}, "R1");
      apply({25'h0, 7'(m)}, "R2");
    end

    // Every funct3 under each funct-decoded major, with a spread of funct7 values
    for (int k = 0; k < 8; k++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int j = 0; j < 6; j++) begin
          seed = next_rand(seed);
          apply({f7set[j], seed[24:15], 3'(f3), seed[11:7], majors[k]},
                tag_for(majors[k], 3'(f3), f7set[j]));
        end
      end
    end

    // Directed corners
    apply(32'h0200_1013, "R7");  // shift-left-imm with bit 25 set
    apply(32'h01F0_9093, "R7");  // shift-left-imm, amount 31, legal
    apply(32'h4030_5213, "R6");  // shift-right-arith imm
    apply(32'h4020_8033, "R6");  // sub
    apply(32'h1200_0073, "R8");  // vm fence, zero operands
    apply(32'h13FF_8073, "R8");  // vm fence with nonzero fields
    apply(32'h3020_0073, "R8");
    apply(32'h1050_0073, "R8");
    apply(32'h3420_4073, "R9");  // funct3 100 under system

    // Full sweep of the system function field with funct3 000 (R8)
    for (int f = 0; f < 4096; f++) begin
      seed = next_rand(seed);
      apply({12'(f), seed[19:15], 3'b000, seed[11:7], 7'h73}, "R8");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired, run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule